// File: doc/BRIEF.md
# Serial-Programmed Dual DAC Code Register Front End

This block is the digital control side of a two-channel, 16-bit digital-to-analog converter. A host writes 24-bit serial frames into it. The frames arrive MSB first, framed by an active-low select line, on a slow serial clock. That clock, the select line and the data line are brought into the system clock domain through synchronizers. Each channel has its own pair of registers:

- an input register, which holds the value written by the host;
- a DAC register, which holds the code currently driven to the converter core.

The DAC register takes its value in one of two ways. An active-low load strobe copies every input register into its DAC register. While the strobe is held low, a write goes straight through to the DAC register. An active-low clear input forces every DAC register to the zero-volt code and leaves the input registers alone.

Each channel also has an 8-bit signed offset register, counted in eighths of an LSB. The offset is added to the code before the code reaches the parallel output. A coding input chooses between straight binary and two's complement interpretation of all codes.

A read frame asks for one register. That register's contents are returned on the serial output during the following frame. A write frame is itself pushed out on the serial output during the following frame, so several devices can share one chain.

Top module: `dac_front_end`

## Requirements

**Frame layout.** Bits are numbered 23 (first on the wire) down to 0.

| Bits | Field | Meaning |
|---|---|---|
| 23 | rw | 1 = read, 0 = write |
| 22 | reserved | ignored |
| 21:19 | register select | 010 = data, 011 = offset, any other value = no register |
| 18:16 | channel address | 000 = channel 0, 001 = channel 1, 100 = all channels |
| 15:0 | payload | data, or for the offset register a signed offset in bits 7:0 |

- R1: After reset, every input, DAC and offset register is zero. With binary coding selected, every channel output reads 0x0000 and the serial output is 0.
- R2: A data write with the load strobe high changes only the input register. The channel output keeps its value until the strobe falls. The falling edge copies every input register to its DAC register.
- R3: While the load strobe is held low, a data write reaches the DAC register, and so the channel output, as soon as the frame completes.
- R4: A frame is acted on only when the select line rises after exactly 24 falling edges of the serial clock. Bits are sampled on the falling edge. Shorter and longer frames change no register.
- R5: A read frame (bit 23 = 1) loads a 24-bit reply into the serial output. The reply is shifted out MSB first during the next frame, one bit ahead of each falling serial-clock edge. Its layout is:
  - bits 23:16 repeat bits 23:16 of the request;
  - bits 15:0 hold the addressed input register (data select), or the offset zero-extended (offset select).
- R6: After any complete write frame, the next frame shifts out on the serial output the 24 bits of that write frame, unchanged. This allows daisy chaining.
- R7: Each channel output is the DAC code plus offset/8, rounded toward minus infinity and saturated to the 16-bit code range. The offset runs from +127 to -128 eighths, so from +15.875 LSB to -16 LSB. A zero offset leaves the code unchanged.
- R8: While the clear input is low, every DAC register holds the zero-volt code: 0x8000 in binary coding. The input registers keep their contents, so a later load strobe restores them.
- R9: With two's complement coding selected:
  - codes are signed;
  - the zero-volt code used by clear is 0x0000;
  - saturation limits are 0x8000 and 0x7FFF.
- R10: Channel address 100 writes every channel. Any other address that names no channel is ignored. A register select other than 010 or 011 changes no register.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, idles high; data sampled on its falling edge |
| sync_ni | input | 1 | Active-low frame select |
| sdin_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out (readback and daisy chain) |
| load_ni | input | 1 | Active-low load strobe |
| clr_ni | input | 1 | Active-low clear to zero-volt code |
| twos_i | input | 1 | 1 = two's complement coding, 0 = straight binary |
| code_o | output | 32 | Corrected channel codes, channel k in bits 16k+15:16k |

## Verification

The hardest state to reach from the ports is a channel whose input register and DAC register differ at the moment clear is applied. Only that state shows that clear leaves the input registers untouched.

The bench builds that state on purpose:

1. With the strobe high, it writes a new value to one channel, so that channel's output still shows an older code.
2. It holds clear low and checks that both channels read the zero-volt code.
3. It releases clear and pulses the strobe, then checks that each channel shows the value left waiting in its input register.

Saturation at both ends is reached by pairing full-scale codes with the extreme offsets, in each coding.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;
  localparam int HDR_W  = 8;
  localparam int FRAC_W = 3;

  localparam logic [2:0] REG_DATA = 3'b010;
  localparam logic [2:0] REG_OFF  = 3'b011;
  localparam logic [2:0] ADDR_ALL = 3'b100;

  typedef struct packed {
    logic       rw;
    logic       rsvd;
    logic [2:0] reg_sel;
    logic [2:0] addr;
  } hdr_t;
endpackage

// File: rtl/sync_bits.sv
module sync_bits #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '1;
    end else begin
      pipe_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx #(
  parameter int FRAME_W = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_i,
  input  logic               sync_ni,
  input  logic               sdin_i,
  input  logic               rd_load_i,
  input  logic [FRAME_W-1:0] rd_word_i,
  output logic               sclk_fall_o,
  output logic               frame_vld_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic               sdo_o
);
  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

  logic               sclk_q, sync_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] sr_q;
  logic               sync_fall, sync_rise, shift_en;

  assign sclk_fall_o = sclk_q & ~sclk_i;
  assign sync_fall   = sync_q & ~sync_ni;
  assign sync_rise   = ~sync_q & sync_ni;
  assign shift_en    = ~sync_ni & sclk_fall_o;
  assign frame_vld_o = sync_rise && (cnt_q == CNT_FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b1;
      sync_q <= 1'b1;
      cnt_q  <= '0;
      sr_q   <= '0;
    end else begin
      sclk_q <= sclk_i;
      sync_q <= sync_ni;
      // saturate one past full so long frames are rejected
      if (sync_fall)                           cnt_q <= '0;
      else if (shift_en && cnt_q != CNT_OVER)  cnt_q <= cnt_q + 1'b1;
      if (frame_vld_o && rd_load_i)  sr_q <= rd_word_i;
      else if (shift_en)             sr_q <= {sr_q[FRAME_W-2:0], sdin_i};
    end
  end

  assign frame_o = sr_q;
  assign sdo_o   = sr_q[FRAME_W-1];
endmodule

// File: rtl/dac_chan.sv
module dac_chan
  import dac_fe_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OFF_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              twos_i,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic              direct_i,
  input  logic              wr_data_i,
  input  logic              wr_off_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [DATA_W-1:0] in_o,
  output logic [DATA_W-1:0] dac_o,
  output logic [OFF_W-1:0]  off_o,
  output logic [DATA_W-1:0] code_o
);
  localparam int ACC_W = DATA_W + FRAC_W + 2;
  localparam logic [DATA_W-1:0] MID = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] in_q, dac_q, flip, zero_code, ubin, corr;
  logic [OFF_W-1:0]  off_q;
  logic [ACC_W-1:0]  off_ext, acc;

  assign flip      = twos_i ? MID : '0;
  assign zero_code = twos_i ? '0 : MID;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q  <= '0;
      dac_q <= '0;
      off_q <= '0;
    end else begin
      if (wr_data_i) in_q  <= data_i;
      if (wr_off_i)  off_q <= off_i;
      if (clr_i)                       dac_q <= zero_code;
      else if (wr_data_i && direct_i)  dac_q <= data_i;
      else if (load_i)                 dac_q <= in_q;
    end
  end

  // offset applied in offset-binary domain so one clamp serves both codings
  assign ubin    = dac_q ^ flip;
  assign off_ext = {{(ACC_W-OFF_W){off_q[OFF_W-1]}}, off_q};
  assign acc     = {2'b00, ubin, {FRAC_W{1'b0}}} + off_ext;

  always_comb begin
    if (acc[ACC_W-1])      corr = '0;
    else if (acc[ACC_W-2]) corr = '1;
    else                   corr = acc[DATA_W+FRAC_W-1:FRAC_W];
  end

  assign code_o = corr ^ flip;
  assign in_o   = in_q;
  assign dac_o  = dac_q;
  assign off_o  = off_q;
endmodule

// File: rtl/dac_front_end.sv
module dac_front_end
  import dac_fe_pkg::*;
#(
  parameter int N_CH        = 2,
  parameter int DATA_W      = 16,
  parameter int OFF_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sclk_i,
  input  logic                   sync_ni,
  input  logic                   sdin_i,
  output logic                   sdo_o,
  input  logic                   load_ni,
  input  logic                   clr_ni,
  input  logic                   twos_i,
  output logic [N_CH*DATA_W-1:0] code_o
);
  localparam int FRAME_W = HDR_W + DATA_W;

  logic [4:0] raw_in, syn;
  logic       sclk_s, sync_s, sdin_s, load_q, clr_s, clr_q;
  logic       load_d, load_fall;

  assign raw_in = {sclk_i, sync_ni, sdin_i, load_ni, clr_ni};

  sync_bits #(.W(5), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw_in), .q_o(syn)
  );

  assign {sclk_s, sync_s, sdin_s, load_q, clr_s} = syn;
  assign clr_q = ~clr_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) load_d <= 1'b1;
    else         load_d <= load_q;
  end
  assign load_fall = load_d & ~load_q;

  logic               sclk_fall, frame_vld, rd_load;
  logic [FRAME_W-1:0] frame, rd_word;
  logic [DATA_W-1:0]  rd_val;
  hdr_t               hdr;
  logic               wr;

  spi_frame_rx #(.FRAME_W(FRAME_W)) i_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_i     (sclk_s),
    .sync_ni    (sync_s),
    .sdin_i     (sdin_s),
    .rd_load_i  (rd_load),
    .rd_word_i  (rd_word),
    .sclk_fall_o(sclk_fall),
    .frame_vld_o(frame_vld),
    .frame_o    (frame),
    .sdo_o      (sdo_o)
  );

  assign hdr     = hdr_t'(frame[FRAME_W-1 -: HDR_W]);
  assign wr      = frame_vld & ~hdr.rw;
  assign rd_load = frame_vld & hdr.rw;

  logic [N_CH*DATA_W-1:0] in_flat, dac_flat;
  logic [N_CH*OFF_W-1:0]  off_flat;

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    logic sel;
    assign sel = (hdr.addr == ADDR_ALL) || (hdr.addr == 3'(k));

    dac_chan #(.DATA_W(DATA_W), .OFF_W(OFF_W)) i_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .twos_i   (twos_i),
      .clr_i    (clr_q),
      .load_i   (load_fall),
      .direct_i (~load_q),
      .wr_data_i(wr && sel && hdr.reg_sel == REG_DATA),
      .wr_off_i (wr && sel && hdr.reg_sel == REG_OFF),
      .data_i   (frame[DATA_W-1:0]),
      .off_i    (frame[OFF_W-1:0]),
      .in_o     (in_flat[k*DATA_W +: DATA_W]),
      .dac_o    (dac_flat[k*DATA_W +: DATA_W]),
      .off_o    (off_flat[k*OFF_W +: OFF_W]),
      .code_o   (code_o[k*DATA_W +: DATA_W])
    );
  end

  always_comb begin
    rd_val = '0;
    for (int k = 0; k < N_CH; k++) begin
      if (hdr.addr == 3'(k)) begin
        if (hdr.reg_sel == REG_DATA)     rd_val = in_flat[k*DATA_W +: DATA_W];
        else if (hdr.reg_sel == REG_OFF) rd_val = DATA_W'(off_flat[k*OFF_W +: OFF_W]);
      end
    end
  end

  assign rd_word = {hdr, rd_val};
endmodule

// File: rtl/dac_front_end_chk.sv
module dac_front_end_chk #(
  parameter int N_CH   = 2,
  parameter int DATA_W = 16,
  parameter int OFF_W  = 8
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   twos_i,
  input logic                   clr_q,
  input logic                   load_q,
  input logic                   frame_vld,
  input logic                   sclk_fall,
  input logic                   sdo_o,
  input logic [N_CH*DATA_W-1:0] in_flat,
  input logic [N_CH*DATA_W-1:0] dac_flat,
  input logic [N_CH*OFF_W-1:0]  off_flat,
  input logic [N_CH*DATA_W-1:0] code_o
);
  localparam logic [DATA_W-1:0] MID = {1'b1, {(DATA_W-1){1'b0}}};

  // R2
  dac_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_q && load_q) |=> $stable(dac_flat));

  // R4
  no_stray_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_vld |=> ($stable(in_flat) && $stable(off_flat)));

  // R6
  sdo_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sclk_fall && !frame_vld) |=> $stable(sdo_o));

  for (genvar k = 0; k < N_CH; k++) begin : g_chk
    // R8
    clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_q |=> (dac_flat[k*DATA_W +: DATA_W] == ($past(twos_i) ? '0 : MID)));

    // R7
    zero_off_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (off_flat[k*OFF_W +: OFF_W] == '0) |->
        (code_o[k*DATA_W +: DATA_W] == dac_flat[k*DATA_W +: DATA_W]));
  end
endmodule

bind dac_front_end dac_front_end_chk #(.N_CH(N_CH), .DATA_W(DATA_W), .OFF_W(OFF_W)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .twos_i   (twos_i),
  .clr_q    (clr_q),
  .load_q   (load_q),
  .frame_vld(frame_vld),
  .sclk_fall(sclk_fall),
  .sdo_o    (sdo_o),
  .in_flat  (in_flat),
  .dac_flat (dac_flat),
  .off_flat (off_flat),
  .code_o   (code_o)
);

// File: tb/test_dac_front_end.sv
module test_dac_front_end;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCLK  = 8;

  logic        clk = 1'b0;
  logic        rst_ni, sclk, sync_n, sdin, load_n, clr_n, twos;
  logic        sdo;
  logic [31:0] code;
  int          n_tests = 0;
  int          n_fail  = 0;
  logic        done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_front_end i_dac_front_end (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .sync_ni(sync_n), .sdin_i(sdin),
    .sdo_o(sdo), .load_ni(load_n), .clr_ni(clr_n), .twos_i(twos), .code_o(code)
  );

  function automatic logic [23:0] fw(logic rw, logic [2:0] rs, logic [2:0] a, logic [15:0] d);
    return {rw, 1'b0, rs, a, d};
  endfunction

  function automatic logic [15:0] ch(int k);
    return code[k*16 +: 16];
  endfunction

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic frame(logic [23:0] w, int nbits, output logic [23:0] got);
    got = '0;
    sync_n = 1'b0;
    wait_clk(4);
    for (int i = 0; i < nbits; i++) begin
      sdin = (i < 24) ? w[23-i] : 1'b0;
      wait_clk(HALF_SCLK);
      if (i < 24) got[23-i] = sdo;
      sclk = 1'b0;
      wait_clk(HALF_SCLK);
      sclk = 1'b1;
    end
    wait_clk(4);
    sync_n = 1'b1;
    wait_clk(12);
  endtask

  task automatic send(logic [23:0] w);
    logic [23:0] g;
    frame(w, 24, g);
  endtask

  task automatic pulse_load();
    load_n = 1'b0;
    wait_clk(6);
    load_n = 1'b1;
    wait_clk(6);
  endtask

  task automatic t_reset();
    chk("R1 ch0 after reset", ch(0), 0);
    chk("R1 ch1 after reset", ch(1), 0);
    chk("R1 sdo after reset", sdo, 0);
  endtask

  task automatic t_load();
    load_n = 1'b1;
    send(fw(0, 3'b010, 3'b000, 16'h1234));
    chk("R2 ch0 held before load", ch(0), 0);
    pulse_load();
    chk("R2 ch0 after load", ch(0), 16'h1234);
    chk("R2 ch1 after load", ch(1), 0);
  endtask

  task automatic t_direct();
    load_n = 1'b0;
    wait_clk(6);
    send(fw(0, 3'b010, 3'b001, 16'hBEEF));
    chk("R3 ch1 direct write", ch(1), 16'hBEEF);
  endtask

  task automatic t_bad_length();
    logic [23:0] g;
    frame(fw(0, 3'b010, 3'b000, 16'h5555), 23, g);
    chk("R4 23-bit frame ignored", ch(0), 16'h1234);
    frame(fw(0, 3'b010, 3'b000, 16'h5555), 25, g);
    chk("R4 25-bit frame ignored", ch(0), 16'h1234);
  endtask

  task automatic t_readback();
    logic [23:0] g;
    send(fw(1, 3'b010, 3'b000, 16'h0000));
    frame(fw(0, 3'b000, 3'b000, 16'hABCD), 24, g);
    chk("R5 readback ch0 data", g, 24'h901234);
    chk("R10 reg select 000 ignored", ch(0), 16'h1234);
  endtask

  task automatic t_daisy();
    logic [23:0] g;
    send(fw(0, 3'b110, 3'b001, 16'h0F0F));
    frame(fw(0, 3'b000, 3'b000, 16'h0000), 24, g);
    chk("R6 previous frame on sdo", g, fw(0, 3'b110, 3'b001, 16'h0F0F));
    chk("R10 reg select 110 ignored", ch(1), 16'hBEEF);
  endtask

  task automatic t_offset();
    logic [23:0] g;
    send(fw(0, 3'b010, 3'b000, 16'h1000));
    send(fw(0, 3'b011, 3'b000, 16'h000F));
    chk("R7 offset +15/8", ch(0), 16'h1001);
    send(fw(0, 3'b011, 3'b000, 16'h00FF));
    chk("R7 offset -1/8 floors", ch(0), 16'h0FFF);
    send(fw(1, 3'b011, 3'b000, 16'h0000));
    frame(fw(0, 3'b000, 3'b000, 16'h0000), 24, g);
    chk("R5 readback ch0 offset", g, 24'h9800FF);
    send(fw(0, 3'b010, 3'b000, 16'hFFFF));
    send(fw(0, 3'b011, 3'b000, 16'h007F));
    chk("R7 saturate top", ch(0), 16'hFFFF);
    send(fw(0, 3'b010, 3'b000, 16'h0000));
    send(fw(0, 3'b011, 3'b000, 16'h0080));
    chk("R7 saturate bottom", ch(0), 16'h0000);
    send(fw(0, 3'b011, 3'b000, 16'h0000));
  endtask

  task automatic t_all();
    send(fw(0, 3'b010, 3'b100, 16'h4321));
    chk("R10 broadcast ch0", ch(0), 16'h4321);
    chk("R10 broadcast ch1", ch(1), 16'h4321);
    send(fw(0, 3'b010, 3'b101, 16'h1111));
    chk("R10 bad address ch0", ch(0), 16'h4321);
    chk("R10 bad address ch1", ch(1), 16'h4321);
  endtask

  task automatic t_clear();
    load_n = 1'b1;
    wait_clk(6);
    send(fw(0, 3'b010, 3'b001, 16'h7777));
    chk("R2 ch1 buffered", ch(1), 16'h4321);
    clr_n = 1'b0;
    wait_clk(6);
    chk("R8 ch0 cleared", ch(0), 16'h8000);
    chk("R8 ch1 cleared", ch(1), 16'h8000);
    clr_n = 1'b1;
    wait_clk(6);
    pulse_load();
    chk("R8 ch0 input kept", ch(0), 16'h4321);
    chk("R8 ch1 input kept", ch(1), 16'h7777);
  endtask

  task automatic t_twos();
    twos = 1'b1;
    clr_n = 1'b0;
    wait_clk(6);
    chk("R9 clear ch0 twos", ch(0), 16'h0000);
    chk("R9 clear ch1 twos", ch(1), 16'h0000);
    clr_n = 1'b1;
    load_n = 1'b0;
    wait_clk(6);
    send(fw(0, 3'b010, 3'b000, 16'h7FFF));
    send(fw(0, 3'b011, 3'b000, 16'h007F));
    chk("R9 saturate positive", ch(0), 16'h7FFF);
    send(fw(0, 3'b010, 3'b000, 16'h8000));
    send(fw(0, 3'b011, 3'b000, 16'h0080));
    chk("R9 saturate negative", ch(0), 16'h8000);
    send(fw(0, 3'b010, 3'b000, 16'h0005));
    send(fw(0, 3'b011, 3'b000, 16'h00F8));
    chk("R9 offset -1 LSB", ch(0), 16'h0004);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; sclk = 1'b1; sync_n = 1'b1; sdin = 1'b0;
    load_n = 1'b1; clr_n = 1'b1; twos = 1'b0;
    wait_clk(5);
    rst_ni = 1'b1;
    wait_clk(5);
    t_reset();
    t_load();
    t_direct();
    t_bad_length();
    t_readback();
    t_daisy();
    t_offset();
    t_all();
    t_clear();
    t_twos();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule